// File: doc/BRIEF.md
# Stereo Volume and Soft Mute Stage

This block scales each stereo pair of 20-bit signed audio words by two gains. The first is a volume gain chosen by a 6-bit code. The code steps the level down 1 dB at a time, and the codes above the last step give full silence. The second is a soft-mute gain. It follows a raised-cosine curve, so the level fades out and back in without a click. Both channels always get the same gain.

Three sources can request a mute: a dedicated pin, a control bit, and an out-of-lock request from the upstream receiver. The receiver request can be disabled by control. Every valid input sample moves the fade one step along the curve. After the fade reaches zero gain, a flag reports that the mute is complete. The flag drops on the first sample that moves back toward full gain. Outputs appear one clock after the input strobe. Each output is rounded and saturated back to 20 bits.

Top module: `vol_mute_stage`

## Requirements
- R1: While reset is held, and at its release, `out_valid` is 0, both outputs are 0 and `mute_done` is 0.
- R2: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high. At all other times it is low, and both outputs keep their last values.
- R3: With `vol_code` = 0 and no mute in progress, each output equals its input sample exactly.
- R4: For `vol_code` = k with 1 ≤ k ≤ 60, each output equals input × 10^(−k/20). The allowed error is |input|·3/65536 + 2 LSB.
- R5: Every `vol_code` from 61 to 63 gives an output of 0 on both channels.
- R6: Left and right use the same gain, taken from the one volume code sampled in the strobe cycle.
- R7: A mute requested by `mute_pin` = 1 or by `mute_bit` = 1 makes the n-th sample after the request (n = 0..31) leave with gain (1+cos(π·n/32))/2 × volume gain. From the 32nd sample on, the output is 0.
- R8: When `rx_unlock` = 1 and `auto_mute_en` = 1, the same soft mute is engaged. When `auto_mute_en` = 0, `rx_unlock` has no effect on the output or on `mute_done`.
- R9: `mute_done` rises at the output of the 32nd muted sample. It falls at the output of the first sample after all mute requests are gone. Sample n after release (n = 0..32) leaves with gain (1+cos(π·(32−n)/32))/2.
- R10: A change of `vol_code` applies from the next strobe on. Each sample uses the code that was present in its own strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 20 | Left sample, signed |
| in_right | input | 20 | Right sample, signed |
| vol_code | input | 6 | Attenuation in dB; 61 and above give silence |
| mute_pin | input | 1 | Mute request from the pin |
| mute_bit | input | 1 | Mute request from the control register |
| rx_unlock | input | 1 | Receiver out-of-lock mute request |
| auto_mute_en | input | 1 | Lets `rx_unlock` engage the mute |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 20 | Scaled left sample, signed |
| out_right | output | 20 | Scaled right sample, signed |
| mute_done | output | 1 | Fade has reached zero gain |

## Verification
The fade position lives in a single counter, so any fault in it shows at the ports at once. An off-by-one step shows up as a sample fading at the wrong cosine level. It also moves the silence and the `mute_done` edge one strobe early or late, which the bench detects on the very next output. A bad volume table entry appears on the first sample sent with that code. A stuck fade index either blocks unity gain after a release or keeps the output from ever reaching zero. The bench checks every sample of both fade directions.

// File: rtl/vms_pkg.sv
package vms_pkg;

  localparam int unsigned FRAC = 16;          // gain fraction bits
  localparam int unsigned CW   = FRAC + 1;    // gain width (1.0 representable)

  // 10^(-1/20) in Q30, iterated per dB step
  localparam longint unsigned DB_STEP_Q30 = 64'd956973408;

  function automatic logic [CW-1:0] vol_coef(input int code);
    longint unsigned acc;
    acc = 64'd1 << 30;
    for (int i = 0; i < 64; i++) begin
      if (i < code) acc = (acc * DB_STEP_Q30 + (64'd1 << 29)) >> 30;
    end
    return CW'((acc + (64'd1 << 13)) >> 14);
  endfunction

  // raised-cosine gain (1+cos(pi*i/n))/2 in Q16, Taylor series in Q28
  function automatic logic [CW-1:0] ramp_coef(input int i, input int n);
    longint th, th2, term, sum, g;
    if (i <= 0) return CW'(64'd1 << FRAC);
    if (i >= n) return '0;
    th   = (64'sd843314857 * longint'(i)) / longint'(n);
    th2  = (th * th) >>> 28;
    term = 64'sd1 <<< 28;
    sum  = term;
    for (int k = 1; k <= 9; k++) begin
      term = -((term * th2) >>> 28);
      term = term / longint'((2 * k - 1) * (2 * k));
      sum  = sum + term;
    end
    g = ((64'sd1 <<< 28) + sum + (64'sd1 <<< 12)) >>> 13;
    if (g < 0) g = 0;
    if (g > (64'sd1 <<< FRAC)) g = 64'sd1 <<< FRAC;
    return CW'(g);
  endfunction

endpackage

// File: rtl/vms_vol_rom.sv
module vms_vol_rom
  import vms_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int MAX_ATT = 60
) (
  input  logic [CODE_W-1:0] code,
  output logic [CW-1:0]     coef
);
  localparam int ENTRIES = 1 << CODE_W;

  logic [CW-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
    if (g <= MAX_ATT) begin : g_step
      assign tbl[g] = vol_coef(g);
    end else begin : g_silent
      assign tbl[g] = '0;
    end
  end

  assign coef = tbl[code];
endmodule

// File: rtl/vms_ramp_ctrl.sv
module vms_ramp_ctrl
  import vms_pkg::*;
#(
  parameter int RAMP_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          mute_req,
  output logic [CW-1:0] coef,
  output logic          done
);
  localparam int IW = $clog2(RAMP_LEN + 1);
  localparam logic [IW-1:0] LAST = IW'(RAMP_LEN);

  logic [IW-1:0] idx_q, idx_nx;
  logic          done_q, done_nx;
  logic [CW-1:0] tbl [RAMP_LEN + 1];

  for (genvar g = 0; g <= RAMP_LEN; g++) begin : g_tbl
    assign tbl[g] = ramp_coef(g, RAMP_LEN);
  end

  always_comb begin
    idx_nx  = idx_q;
    done_nx = done_q;
    if (step) begin
      if (mute_req && idx_q != LAST)    idx_nx = idx_q + 1'b1;
      else if (!mute_req && idx_q != '0) idx_nx = idx_q - 1'b1;
      done_nx = (idx_nx == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      idx_q  <= idx_nx;
      done_q <= done_nx;
    end
  end

  assign coef = tbl[idx_q];
  assign done = done_q;

  // R9
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx_q));
  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mute_req) && $past(step));
  // R9
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> !$past(mute_req));
  // R8
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_req && idx_q == '0) |=> idx_q == '0);
endmodule

// File: rtl/vms_gain_mult.sv
module vms_gain_mult
  import vms_pkg::*;
#(
  parameter int DW = 20
) (
  input  logic signed [DW-1:0] sample,
  input  logic        [CW-1:0] gain,
  output logic signed [DW-1:0] result
);
  localparam int PW = DW + CW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (FRAC - 1));
  localparam logic signed [PW-1:0] HI   = PW'((64'd1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] LO   = -HI - PW'(1);

  logic signed [PW-1:0] prod, shifted;

  always_comb begin
    prod    = $signed(sample) * $signed({1'b0, gain});
    shifted = (prod + HALF) >>> FRAC;
    if (shifted > HI)      result = HI[DW-1:0];
    else if (shifted < LO) result = LO[DW-1:0];
    else                   result = shifted[DW-1:0];
  end
endmodule

// File: rtl/vol_mute_stage.sv
module vol_mute_stage
  import vms_pkg::*;
#(
  parameter int DW       = 20,
  parameter int CODE_W   = 6,
  parameter int MAX_ATT  = 60,
  parameter int RAMP_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic [CODE_W-1:0]    vol_code,
  input  logic                 mute_pin,
  input  logic                 mute_bit,
  input  logic                 rx_unlock,
  input  logic                 auto_mute_en,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic                 mute_done
);
  localparam int NCH = 2;

  // reset: asserted asynchronously, released after two clocks
  logic rst_s1_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  logic          mute_req;
  logic [CW-1:0] vol_c, ramp_c, gain_c;
  logic [2*CW-1:0] gprod, gsum;

  assign mute_req = mute_pin | mute_bit | (rx_unlock & auto_mute_en);

  vms_vol_rom #(.CODE_W(CODE_W), .MAX_ATT(MAX_ATT)) vol_rom_i (
    .code (vol_code),
    .coef (vol_c)
  );

  vms_ramp_ctrl #(.RAMP_LEN(RAMP_LEN)) ramp_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .step     (in_valid),
    .mute_req (mute_req),
    .coef     (ramp_c),
    .done     (mute_done)
  );

  always_comb begin
    gprod  = vol_c * ramp_c;
    gsum   = gprod + (2*CW)'(64'd1 << (FRAC - 1));
    gain_c = gsum[FRAC +: CW];
  end

  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_mul [NCH];
  logic signed [DW-1:0] ch_q   [NCH];
  logic signed [DW-1:0] ch_nx  [NCH];

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vms_gain_mult #(.DW(DW)) mult_i (
      .sample (ch_in[c]),
      .gain   (gain_c),
      .result (ch_mul[c])
    );
    assign ch_nx[c] = in_valid ? ch_mul[c] : ch_q[c];
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)      ch_q[c] <= '0;
      else if (in_valid) ch_q[c] <= ch_nx[c];
    end
  end

  logic vld_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= 1'b0;
    else          vld_q <= in_valid;
  end

  assign out_valid = vld_q;
  assign out_left  = ch_q[0];
  assign out_right = ch_q[1];

  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    logic signed [DW:0] e;
    e = {v[DW-1], v};
    return (e < 0) ? -e : e;
  endfunction

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right));
  // R5
  silent_code_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && vol_code > CODE_W'(MAX_ATT)) |=> out_left == '0 && out_right == '0);
  // R7
  no_gain_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> mag(out_left) <= mag($past(in_left)) && mag(out_right) <= mag($past(in_right)));
  // R9
  done_silent_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && mute_done && mute_req) |=> out_left == '0 && out_right == '0);
endmodule

// File: tb/vol_mute_stage_tb.sv
module vol_mute_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [19:0] in_left = '0, in_right = '0;
  logic [5:0] vol_code = '0;
  logic mute_pin = 1'b0, mute_bit = 1'b0, rx_unlock = 1'b0, auto_mute_en = 1'b0;
  logic out_valid, mute_done;
  logic signed [19:0] out_left, out_right;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vol_mute_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .vol_code(vol_code), .mute_pin(mute_pin),
    .mute_bit(mute_bit), .rx_unlock(rx_unlock), .auto_mute_en(auto_mute_en),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .mute_done(mute_done)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk_eq(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_gain(input string req, input int s, input int got, input real g);
    real e, tol, d;
    n_chk++;
    e = s * g;
    tol = ((s < 0) ? -s : s) * 3.0 / 65536.0 + 2.0;
    d = got - e;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0.2f", req, got, e);
    end
  endtask

  function automatic real db_gain(input int k);
    return 10.0 ** (-k / 20.0);
  endfunction

  function automatic real fade(input int n);
    if (n >= 32) return 0.0;
    return (1.0 + $cos(PI * n / 32.0)) / 2.0;
  endfunction

  // one strobe at a negedge; results read at the following negedge
  task automatic send(input int l, input int r, output int ol, output int orr, output bit ov);
    in_left  = 20'(l);
    in_right = 20'(r);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ov  = out_valid;
    ol  = int'(out_left);
    orr = int'(out_right);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 valid", int'(out_valid), 0);
    chk_eq("R1 left", int'(out_left), 0);
    chk_eq("R1 done", int'(mute_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1 right", int'(out_right), 0);
  endtask

  task automatic t_unity();
    int ol, orr; bit ov;
    vol_code = 6'd0;
    send(524287, -524288, ol, orr, ov);
    chk_eq("R2 strobe", int'(ov), 1);
    chk_eq("R3 left max", ol, 524287);
    chk_eq("R3 right min", orr, -524288);
    send(12345, -1, ol, orr, ov);
    chk_eq("R3 left", ol, 12345);
    chk_eq("R3 right", orr, -1);
    @(negedge clk);
    chk_eq("R2 idle strobe", int'(out_valid), 0);
    chk_eq("R2 hold", int'(out_left), 12345);
  endtask

  task automatic t_steps();
    int ol, orr; bit ov;
    int codes [5] = '{1, 6, 20, 45, 60};
    foreach (codes[i]) begin
      vol_code = 6'(codes[i]);
      send(400000, -300000, ol, orr, ov);
      chk_gain("R4 left", 400000, ol, db_gain(codes[i]));
      chk_gain("R6 right", -300000, orr, db_gain(codes[i]));
    end
  endtask

  task automatic t_silent();
    int ol, orr; bit ov;
    for (int c = 61; c < 64; c++) begin
      vol_code = 6'(c);
      send(500000, -500000, ol, orr, ov);
      chk_eq("R5 left", ol, 0);
      chk_eq("R5 right", orr, 0);
    end
  endtask

  task automatic t_boundary();
    int ol, orr; bit ov;
    vol_code = 6'd0;
    send(300000, 300000, ol, orr, ov);
    chk_eq("R10 before", ol, 300000);
    vol_code = 6'd6;
    send(300000, 300000, ol, orr, ov);
    chk_gain("R10 after", 300000, ol, db_gain(6));
    chk_gain("R10 right", 300000, orr, db_gain(6));
  endtask

  // mute via selected source, fade down, check done, release and fade up
  task automatic t_fade(input int src, input string req);
    int ol, orr; bit ov;
    vol_code = 6'd0;
    if (src == 0) mute_pin = 1'b1;
    else if (src == 1) mute_bit = 1'b1;
    else begin auto_mute_en = 1'b1; rx_unlock = 1'b1; end
    for (int n = 0; n < 32; n++) begin
      send(500000, -250000, ol, orr, ov);
      chk_gain(req, 500000, ol, fade(n));
      chk_gain(req, -250000, orr, fade(n));
      if (n == 30) chk_eq("R9 done early", int'(mute_done), 0);
    end
    chk_eq("R9 done rise", int'(mute_done), 1);
    send(500000, -250000, ol, orr, ov);
    chk_eq(req, ol, 0);
    mute_pin = 1'b0; mute_bit = 1'b0; rx_unlock = 1'b0; auto_mute_en = 1'b0;
    for (int n = 0; n <= 32; n++) begin
      send(500000, -250000, ol, orr, ov);
      chk_gain("R9 release", 500000, ol, fade(32 - n));
      if (n == 0) chk_eq("R9 done fall", int'(mute_done), 0);
    end
    send(500000, -250000, ol, orr, ov);
    chk_eq("R9 unity back", ol, 500000);
  endtask

  task automatic t_auto_off();
    int ol, orr; bit ov;
    vol_code = 6'd0;
    auto_mute_en = 1'b0;
    rx_unlock = 1'b1;
    for (int n = 0; n < 40; n++) begin
      send(222222, -111111, ol, orr, ov);
      if (n == 39) begin
        chk_eq("R8 off left", ol, 222222);
        chk_eq("R8 off right", orr, -111111);
        chk_eq("R8 off done", int'(mute_done), 0);
      end
    end
    rx_unlock = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unity();
    t_steps();
    t_silent();
    t_boundary();
    t_fade(0, "R7 pin fade");
    t_fade(1, "R7 bit fade");
    t_fade(2, "R8 auto fade");
    t_auto_off();
    summary();
    $finish;
  end
endmodule